// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sits between an internal request port and an external asynchronous-style memory bus. It runs on the external bus clock. Each request is turned into a sequence of timed strobes on a 24-bit address bus and a 16-bit data bus. The bus carries eight active-low chip selects, active-low byte-lane controls, one active-low read strobe and one active-low write strobe. Every chip-select area has its own timing set: edge delays for chip select, the strobes and data drive; separate wait counts for the first and the following halfwords; and trailing extension counts.

A 32-bit request to the 16-bit bus becomes a two-halfword page burst. The lower halfword goes first, and chip select is held across both halfwords. The second halfword uses the shorter page wait count. After the last halfword, chip select (and, on writes, data drive) may be stretched. One idle hold clock then follows, and during it the requester receives a one-clock ready pulse, together with the read data for reads. The requester holds its request until that pulse. The controller latches every request field at acceptance.

Top module: `xbus_waitctl`

## Requirements
- R1: Out of reset, and whenever no transaction is in progress, every chip select, byte control and strobe is high, data output enable is low, the data output is zero, the address is zero and ready is low.
- R2: A request is accepted on a clock edge where the controller is idle and req_valid is high. Changes on any request input after acceptance have no effect on the bus or the returned data.
- R3: Area i's timing fields sit at cfg_timing[33*i +: 33], as eleven 3-bit fields at bit offsets 0 cs delay, 3 read-strobe delay, 6 write-strobe delay, 9 data-drive delay, 12 data-drive tail, 15 read wait, 18 page read wait, 21 write wait, 24 page write wait, 27 read cs tail, 30 write cs tail.
- R4: Each halfword lasts W+1 clocks, numbered 0..W. W is the read or write wait for the first halfword and the page read or page write wait for the second.
- R5: Only the selected area's chip select goes low. It asserts at clock min(cs delay, W) of the first halfword and stays low through every later halfword. The byte controls are the inverse of the active lanes while chip select is low and all-high otherwise. A narrow request uses req_lanes, where bit 0 is the lower byte, and a wide request uses both lanes.
- R6: The read strobe (on reads) or the write strobe (on writes) is low from clock min(its delay, W) through clock W of every halfword. The two strobes are never low together.
- R7: On writes, data is driven from clock min(data delay, W) through W of each halfword, with that halfword's write data. After the final halfword, driving continues for the data-drive tail count. Data is never driven during reads or the hold clock, and bus_dq_o is zero whenever output enable is low.
- R8: After the final halfword, a tail phase of T clocks follows. T is the read cs tail for reads and the larger of write cs tail and data-drive tail for writes. Chip select stays low for the first cs-tail clocks of the tail.
- R9: After the tail comes one hold clock with all strobes and chip selects high. Ready is high for exactly that clock, and a new request can be accepted no earlier than the following edge.
- R10: A wide request runs the halfword at the even address first, carrying req_wdata[15:0], then the halfword at that address plus 2, carrying req_wdata[31:16].
- R11: On reads, bus_dq_i is sampled on the last clock of each halfword into the matching 16-bit lane of req_rdata. The upper lane is zero for narrow reads. Read data is valid while ready is high.
- R12: From acceptance through the hold clock, bus_addr shows the current halfword's byte address, which is req_hw_addr with a zero appended, plus 2 on the second halfword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit request (two halfwords) |
| req_area | input | 3 | Chip-select area index |
| req_hw_addr | input | 23 | Halfword address |
| req_lanes | input | 2 | Active byte lanes for narrow requests |
| req_wdata | input | 32 | Write data, lower halfword in bits 15:0 |
| req_ready | output | 1 | One-clock completion pulse |
| req_rdata | output | 32 | Read data, valid with ready |
| cfg_timing | input | 264 | Per-area timing fields |
| bus_cs_n | output | 8 | Active-low chip selects |
| bus_bc_n | output | 2 | Active-low byte controls |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_addr | output | 24 | Byte address |
| bus_dq_o | output | 16 | Data bus output value |
| bus_dq_oe | output | 1 | Data bus output enable |
| bus_dq_i | input | 16 | Data bus input value |

## Verification
Requests are issued to areas with all-zero timing, with mixed mid-range timing, with delays larger than the wait counts, and with maximum waits and long tails. Zero timing shows that single-clock halfwords and empty tails work. Oversized delays show whether the clamp keeps every strobe asserted for at least one clock. Wide and narrow reads and writes with different lane masks separate the first-halfword wait from the page wait, and expose the lower-halfword-first order and the tail length rule for writes. Request inputs are scrambled right after acceptance, so any late sampling shows up as a wrong address or wrong data.

// File: rtl/xbw_pkg.sv
package xbw_pkg;
  localparam int FLD_W      = 3;
  localparam int N_FLD      = 11;
  localparam int AREA_CFG_W = FLD_W * N_FLD;

  typedef enum logic [1:0] {PH_IDLE, PH_ACC, PH_TAIL, PH_HOLD} phase_e;

  // Packed so that the first field listed lands in the top bits.
  typedef struct packed {
    logic [FLD_W-1:0] wr_tail;     // 32:30
    logic [FLD_W-1:0] rd_tail;     // 29:27
    logic [FLD_W-1:0] pg_wr_wait;  // 26:24
    logic [FLD_W-1:0] wr_wait;     // 23:21
    logic [FLD_W-1:0] pg_rd_wait;  // 20:18
    logic [FLD_W-1:0] rd_wait;     // 17:15
    logic [FLD_W-1:0] wd_tail;     // 14:12
    logic [FLD_W-1:0] wd_dly;      // 11:9
    logic [FLD_W-1:0] wr_dly;      // 8:6
    logic [FLD_W-1:0] rd_dly;      // 5:3
    logic [FLD_W-1:0] cs_dly;      // 2:0
  } area_cfg_t;

  // A delay past the end clock is pulled back onto it.
  function automatic logic [FLD_W-1:0] clamp_dly(input logic [FLD_W-1:0] dly,
                                                 input logic [FLD_W-1:0] lim);
    return (dly > lim) ? lim : dly;
  endfunction

  // Length of the trailing phase after the last halfword.
  function automatic logic [FLD_W-1:0] tail_len(input logic is_wr, input area_cfg_t c);
    if (!is_wr) return c.rd_tail;
    return (c.wr_tail > c.wd_tail) ? c.wr_tail : c.wd_tail;
  endfunction
endpackage

// File: rtl/xbw_area_mux.sv
module xbw_area_mux
  import xbw_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int SEL_W     = 3
)(
  input  logic [NUM_AREAS*AREA_CFG_W-1:0] cfg_flat,
  input  logic [SEL_W-1:0]                sel,
  output area_cfg_t                       cfg_o
);
  area_cfg_t tab [NUM_AREAS];

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_unpack
    assign tab[i] = area_cfg_t'(cfg_flat[i*AREA_CFG_W +: AREA_CFG_W]);
  end

  assign cfg_o = tab[sel];
endmodule

// File: rtl/xbw_phase_seq.sv
module xbw_phase_seq
  import xbw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             two_hw,
  input  logic [FLD_W-1:0] wait_first,
  input  logic [FLD_W-1:0] wait_page,
  input  logic [FLD_W-1:0] tail_cnt,
  output phase_e           phase,
  output logic             hw_hi,
  output logic [FLD_W-1:0] cnt,
  output logic [FLD_W-1:0] cur_wait,
  output logic             hw_end,
  output logic             tail_end
);
  logic last_hw;

  assign cur_wait = hw_hi ? wait_page : wait_first;
  assign hw_end   = (phase == PH_ACC) && (cnt == cur_wait);
  assign last_hw  = hw_hi || !two_hw;
  assign tail_end = (phase == PH_TAIL) &&
                    (({1'b0, cnt} + {{FLD_W{1'b0}}, 1'b1}) == {1'b0, tail_cnt});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      hw_hi <= 1'b0;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_ACC;
            hw_hi <= 1'b0;
            cnt   <= '0;
          end
        end
        PH_ACC: begin
          if (hw_end) begin
            cnt <= '0;
            if (last_hw) phase <= (tail_cnt == '0) ? PH_HOLD : PH_TAIL;
            else         hw_hi <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_TAIL: begin
          if (tail_end) phase <= PH_HOLD;
          else          cnt   <= cnt + 1'b1;
        end
        PH_HOLD: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbw_pin_drive.sv
module xbw_pin_drive
  import xbw_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int SEL_W     = 3,
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int BC_W      = 2
)(
  input  phase_e                phase,
  input  logic                  hw_hi,
  input  logic [FLD_W-1:0]      cnt,
  input  logic [FLD_W-1:0]      cur_wait,
  input  logic                  is_wr,
  input  logic [SEL_W-1:0]      sel,
  input  logic [BC_W-1:0]       lanes,
  input  logic [ADDR_W-2:0]     hw_addr,
  input  logic [2*DATA_W-1:0]   wdata,
  input  logic [FLD_W-1:0]      cs_dly,
  input  logic [FLD_W-1:0]      rd_dly,
  input  logic [FLD_W-1:0]      wr_dly,
  input  logic [FLD_W-1:0]      wd_dly,
  input  logic [FLD_W-1:0]      wd_tail,
  input  logic [FLD_W-1:0]      cs_tail,
  output logic [NUM_AREAS-1:0]  cs_n,
  output logic [BC_W-1:0]       bc_n,
  output logic                  rd_n,
  output logic                  wr_n,
  output logic [ADDR_W-1:0]     addr,
  output logic [DATA_W-1:0]     dq_o,
  output logic                  dq_oe
);
  logic in_acc, in_tail, cs_act, rd_act, wr_act;

  assign in_acc  = (phase == PH_ACC);
  assign in_tail = (phase == PH_TAIL);

  assign cs_act = (in_acc && (hw_hi || (cnt >= clamp_dly(cs_dly, cur_wait)))) ||
                  (in_tail && (cnt < cs_tail));
  assign rd_act = in_acc && !is_wr && (cnt >= clamp_dly(rd_dly, cur_wait));
  assign wr_act = in_acc &&  is_wr && (cnt >= clamp_dly(wr_dly, cur_wait));
  assign dq_oe  = is_wr && ((in_acc && (cnt >= clamp_dly(wd_dly, cur_wait))) ||
                            (in_tail && (cnt < wd_tail)));

  assign rd_n = !rd_act;
  assign wr_n = !wr_act;
  assign bc_n = cs_act ? ~lanes : '1;
  assign dq_o = !dq_oe ? '0 : (hw_hi ? wdata[2*DATA_W-1:DATA_W] : wdata[DATA_W-1:0]);

  assign addr = (phase == PH_IDLE) ? '0 :
                ({hw_addr, 1'b0} + {{(ADDR_W-2){1'b0}}, hw_hi, 1'b0});

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_cs
    assign cs_n[i] = !(cs_act && (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/xbus_waitctl.sv
module xbus_waitctl
  import xbw_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  localparam int SEL_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1,
  localparam int BC_W     = DATA_W / 8,
  localparam int WIDE_W   = 2 * DATA_W
)(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic                            req_wide,
  input  logic [SEL_W-1:0]                req_area,
  input  logic [ADDR_W-2:0]               req_hw_addr,
  input  logic [BC_W-1:0]                 req_lanes,
  input  logic [WIDE_W-1:0]               req_wdata,
  output logic                            req_ready,
  output logic [WIDE_W-1:0]               req_rdata,
  input  logic [NUM_AREAS*AREA_CFG_W-1:0] cfg_timing,
  output logic [NUM_AREAS-1:0]            bus_cs_n,
  output logic [BC_W-1:0]                 bus_bc_n,
  output logic                            bus_rd_n,
  output logic                            bus_wr_n,
  output logic [ADDR_W-1:0]               bus_addr,
  output logic [DATA_W-1:0]               bus_dq_o,
  output logic                            bus_dq_oe,
  input  logic [DATA_W-1:0]               bus_dq_i
);
  phase_e           phase;
  logic             hw_hi, hw_end, tail_end, start;
  logic [FLD_W-1:0] cnt, cur_wait, wait_first, wait_page, tail_cnt, cs_tail;
  area_cfg_t        acfg;

  logic              wr_q, wide_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-2:0] hwa_q;
  logic [BC_W-1:0]   lanes_q;
  logic [WIDE_W-1:0] wdata_q, rdata_q;

  assign start = (phase == PH_IDLE) && req_valid;

  // Request fields are frozen at acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      sel_q   <= '0;
      hwa_q   <= '0;
      lanes_q <= '0;
      wdata_q <= '0;
    end else if (start) begin
      wr_q    <= req_write;
      wide_q  <= req_wide;
      sel_q   <= req_area;
      hwa_q   <= req_hw_addr;
      lanes_q <= req_wide ? '1 : req_lanes;
      wdata_q <= req_wdata;
    end
  end

  // Read lanes captured on each halfword's end clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (start) begin
      rdata_q <= '0;
    end else if (hw_end && !wr_q) begin
      if (hw_hi) rdata_q[WIDE_W-1:DATA_W] <= bus_dq_i;
      else       rdata_q[DATA_W-1:0]      <= bus_dq_i;
    end
  end

  assign req_rdata = rdata_q;
  assign req_ready = (phase == PH_HOLD);

  xbw_area_mux #(.NUM_AREAS(NUM_AREAS), .SEL_W(SEL_W)) u_mux (
    .cfg_flat (cfg_timing),
    .sel      (sel_q),
    .cfg_o    (acfg)
  );

  assign wait_first = wr_q ? acfg.wr_wait    : acfg.rd_wait;
  assign wait_page  = wr_q ? acfg.pg_wr_wait : acfg.pg_rd_wait;
  assign cs_tail    = wr_q ? acfg.wr_tail    : acfg.rd_tail;
  assign tail_cnt   = tail_len(wr_q, acfg);

  xbw_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .two_hw     (wide_q),
    .wait_first (wait_first),
    .wait_page  (wait_page),
    .tail_cnt   (tail_cnt),
    .phase      (phase),
    .hw_hi      (hw_hi),
    .cnt        (cnt),
    .cur_wait   (cur_wait),
    .hw_end     (hw_end),
    .tail_end   (tail_end)
  );

  xbw_pin_drive #(
    .NUM_AREAS (NUM_AREAS),
    .SEL_W     (SEL_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BC_W      (BC_W)
  ) u_pins (
    .phase    (phase),
    .hw_hi    (hw_hi),
    .cnt      (cnt),
    .cur_wait (cur_wait),
    .is_wr    (wr_q),
    .sel      (sel_q),
    .lanes    (lanes_q),
    .hw_addr  (hwa_q),
    .wdata    (wdata_q),
    .cs_dly   (acfg.cs_dly),
    .rd_dly   (acfg.rd_dly),
    .wr_dly   (acfg.wr_dly),
    .wd_dly   (acfg.wd_dly),
    .wd_tail  (acfg.wd_tail),
    .cs_tail  (cs_tail),
    .cs_n     (bus_cs_n),
    .bc_n     (bus_bc_n),
    .rd_n     (bus_rd_n),
    .wr_n     (bus_wr_n),
    .addr     (bus_addr),
    .dq_o     (bus_dq_o),
    .dq_oe    (bus_dq_oe)
  );
endmodule

// File: rtl/xbw_checker.sv
module xbw_checker
  import xbw_pkg::*;
#(
  parameter int NUM_AREAS = 8
)(
  input logic                 clk,
  input logic                 rst_n,
  input phase_e               phase,
  input logic                 hw_hi,
  input logic                 hw_end,
  input logic                 tail_end,
  input logic [NUM_AREAS-1:0] cs_n,
  input logic                 rd_n,
  input logic                 wr_n,
  input logic                 dq_oe,
  input logic                 ready
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (&cs_n && rd_n && wr_n && !dq_oe && !ready));

  p_one_area_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  p_cs_kept_in_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACC && hw_hi) |-> !(&cs_n));

  p_strobe_on_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_end |-> (rd_n != wr_n));

  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !dq_oe);

  p_tail_strobes_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tail_end |-> (rd_n && wr_n));

  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (&cs_n && rd_n && wr_n && !dq_oe));

  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
endmodule

bind xbus_waitctl xbw_checker #(.NUM_AREAS(NUM_AREAS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phase    (phase),
  .hw_hi    (hw_hi),
  .hw_end   (hw_end),
  .tail_end (tail_end),
  .cs_n     (bus_cs_n),
  .rd_n     (bus_rd_n),
  .wr_n     (bus_wr_n),
  .dq_oe    (bus_dq_oe),
  .ready    (req_ready)
);

// File: tb/xbus_waitctl_tb.sv
module xbus_waitctl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [2:0]   req_area = '0;
  logic [22:0]  req_hw_addr = '0;
  logic [1:0]   req_lanes = '0;
  logic [31:0]  req_wdata = '0;
  logic         req_ready;
  logic [31:0]  req_rdata;
  logic [263:0] cfg_timing;
  logic [7:0]   bus_cs_n;
  logic [1:0]   bus_bc_n;
  logic         bus_rd_n, bus_wr_n, bus_dq_oe;
  logic [23:0]  bus_addr;
  logic [15:0]  bus_dq_o, bus_dq_i;

  always #5 clk = ~clk;

  // Memory model: read value depends only on the address.
  assign bus_dq_i = bus_addr[15:0] ^ 16'h3C5A;

  xbus_waitctl u_dut (.*);

  // Field indices follow R3 (field j occupies bits 3*j+2 : 3*j).
  localparam int CSD = 0, RDD = 1, WRD = 2, WDD = 3, WDT = 4, RW = 5,
                 PRW = 6, WW = 7, PWW = 8, RT = 9, WT = 10;
  int cf [8][11];

  typedef struct packed {
    logic [7:0]  cs_n;
    logic [1:0]  bc_n;
    logic        rd_n;
    logic        wr_n;
    logic [23:0] addr;
    logic [15:0] dq;
    logic        oe;
    logic        rdy;
  } exp_t;
  exp_t q[$];

  int n_tests = 0, n_fail = 0;

  function automatic int mn(int a, int b); return (a < b) ? a : b; endfunction
  function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
    end
  endtask

  task automatic pack_cfg();  // R3 layout
    logic [263:0] v = '0;
    for (int a = 0; a < 8; a++)
      for (int j = 0; j < 11; j++)
        v[a*33 + j*3 +: 3] = 3'(cf[a][j]);
    cfg_timing = v;
  endtask

  task automatic chk_idle();  // R1
    chk(bus_cs_n == 8'hFF, "R1", "idle cs_n", 32'(bus_cs_n), 32'hFF);
    chk(bus_bc_n == 2'b11 && bus_rd_n && bus_wr_n, "R1", "idle strobes",
        {28'd0, bus_bc_n, bus_rd_n, bus_wr_n}, 32'hF);
    chk(!bus_dq_oe && bus_dq_o == 0 && bus_addr == 0 && !req_ready, "R1", "idle bus",
        {bus_dq_oe, req_ready, 6'd0, bus_addr}, 32'h0);
  endtask

  // Behavioural expectation of one transaction, one entry per clock.
  task automatic build(bit wr, bit wide, int a, logic [22:0] ha, logic [1:0] ln, logic [31:0] wd);
    exp_t e;
    int nhw = wide ? 2 : 1;
    logic [23:0] base = {ha, 1'b0};
    logic [1:0] lv = wide ? 2'b11 : ln;
    int tail, cst;
    q.delete();
    for (int h = 0; h < nhw; h++) begin
      int w = (h == 0) ? (wr ? cf[a][WW] : cf[a][RW]) : (wr ? cf[a][PWW] : cf[a][PRW]);
      for (int k = 0; k <= w; k++) begin
        bit cs = (h > 0) || (k >= mn(cf[a][CSD], w));
        e.cs_n = 8'hFF;
        if (cs) e.cs_n[a] = 1'b0;
        e.bc_n = cs ? ~lv : 2'b11;
        e.rd_n = !(!wr && k >= mn(cf[a][RDD], w));
        e.wr_n = !(wr && k >= mn(cf[a][WRD], w));
        e.oe   = wr && (k >= mn(cf[a][WDD], w));
        e.dq   = e.oe ? (h == 1 ? wd[31:16] : wd[15:0]) : 16'h0;
        e.addr = base + 24'(2 * h);
        e.rdy  = 1'b0;
        q.push_back(e);
      end
    end
    cst  = wr ? cf[a][WT] : cf[a][RT];
    tail = wr ? mx(cf[a][WT], cf[a][WDT]) : cf[a][RT];
    for (int t = 0; t < tail; t++) begin
      bit cs = t < cst;
      e.cs_n = 8'hFF;
      if (cs) e.cs_n[a] = 1'b0;
      e.bc_n = cs ? ~lv : 2'b11;
      e.rd_n = 1'b1;
      e.wr_n = 1'b1;
      e.oe   = wr && (t < cf[a][WDT]);
      e.dq   = e.oe ? (wide ? wd[31:16] : wd[15:0]) : 16'h0;
      e.addr = base + 24'(wide ? 2 : 0);
      e.rdy  = 1'b0;
      q.push_back(e);
    end
    e.cs_n = 8'hFF; e.bc_n = 2'b11; e.rd_n = 1'b1; e.wr_n = 1'b1;
    e.oe = 1'b0; e.dq = 16'h0; e.addr = base + 24'(wide ? 2 : 0); e.rdy = 1'b1;
    q.push_back(e);
  endtask

  task automatic run(bit wr, bit wide, int a, logic [22:0] ha, logic [1:0] ln, logic [31:0] wd);
    logic [23:0] base = {ha, 1'b0};
    logic [31:0] exp_rd;
    int n;
    build(wr, wide, a, ha, ln, wd);
    n = q.size();
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wide = wide; req_area = 3'(a);
    req_hw_addr = ha; req_lanes = ln; req_wdata = wd;
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      exp_t e = q[i];
      @(negedge clk);
      chk(bus_cs_n == e.cs_n, "R5/R8", "cs_n", 32'(bus_cs_n), 32'(e.cs_n));
      chk(bus_bc_n == e.bc_n, "R5", "bc_n", 32'(bus_bc_n), 32'(e.bc_n));
      chk(bus_rd_n == e.rd_n && bus_wr_n == e.wr_n, "R6", "rd_n/wr_n",
          {30'd0, bus_rd_n, bus_wr_n}, {30'd0, e.rd_n, e.wr_n});
      chk(bus_dq_oe == e.oe && bus_dq_o == e.dq, "R7", "dq_oe/dq_o",
          {15'd0, bus_dq_oe, bus_dq_o}, {15'd0, e.oe, e.dq});
      chk(bus_addr == e.addr, "R2/R10/R12", "addr", 32'(bus_addr), 32'(e.addr));
      chk(req_ready == e.rdy, "R3/R4/R9", "ready", 32'(req_ready), 32'(e.rdy));
      if (i == 0) begin  // R2: scramble request inputs after acceptance
        req_write = ~wr; req_wide = ~wide; req_area = 3'(a + 3);
        req_hw_addr = ~ha; req_lanes = ~ln; req_wdata = ~wd;
      end
      if (e.rdy) begin
        if (!wr) begin
          logic [15:0] lo = base[15:0] ^ 16'h3C5A;
          logic [15:0] hi = (base[15:0] + 16'd2) ^ 16'h3C5A;
          exp_rd = {wide ? hi : 16'h0, lo};
          chk(req_rdata == exp_rd, "R11", "rdata", req_rdata, exp_rd);
        end
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk_idle();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    for (int a = 0; a < 8; a++)
      for (int j = 0; j < 11; j++)
        cf[a][j] = (a + j) % 4;
    for (int j = 0; j < 11; j++) cf[0][j] = 0;         // all-zero timing
    cf[1] = '{0, 1, 1, 1, 2, 1, 1, 2, 1, 1, 1};         // mixed, data tail beyond cs tail
    cf[2] = '{5, 7, 7, 6, 0, 3, 2, 3, 2, 0, 3};         // delays above waits: clamp
    cf[5] = '{2, 3, 4, 1, 6, 7, 4, 7, 5, 6, 2};         // long waits and tails
    cf[7] = '{1, 0, 2, 0, 1, 2, 0, 4, 0, 2, 0};         // zero page waits
    pack_cfg();

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle();   // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle();   // R1 after reset

    run(1'b0, 1'b0, 0, 23'h001234, 2'b01, 32'h0);
    run(1'b1, 1'b0, 0, 23'h002345, 2'b10, 32'h0000BEEF);
    run(1'b0, 1'b1, 1, 23'h010000, 2'b00, 32'h0);
    run(1'b1, 1'b1, 1, 23'h010002, 2'b00, 32'hCAFE1234);
    run(1'b0, 1'b0, 2, 23'h3ABCDE, 2'b11, 32'h0);
    run(1'b1, 1'b1, 2, 23'h3ABCE0, 2'b00, 32'h87654321);
    run(1'b0, 1'b1, 5, 23'h7FFFF0, 2'b00, 32'h0);
    run(1'b1, 1'b1, 5, 23'h400101, 2'b01, 32'hA5A55A5A);
    run(1'b1, 1'b0, 7, 23'h000777, 2'b11, 32'h0000F00D);
    run(1'b0, 1'b1, 7, 23'h055555, 2'b00, 32'h0);
    run(1'b1, 1'b1, 7, 23'h12345F, 2'b10, 32'h13579BDF);
    run(1'b0, 1'b0, 3, 23'h0000FF, 2'b10, 32'h0);
    run(1'b1, 1'b0, 4, 23'h0ABCDE, 2'b01, 32'h00002468);

    summary();
  end
endmodule